// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns an 8-bit processor's addressing mode, its one or two operand bytes and the two index registers into a resolved operand. The result is one of four kinds: no operand, an immediate byte, a sign-extended branch displacement, or a 16-bit effective address. The execution logic takes the result and uses it. Opcode decoding, instruction execution, program-counter arithmetic and page-crossing cycle penalties belong to other blocks.

A one-cycle `start` pulse presents the mode, both operand bytes and both index values. Modes that need no memory finish with a `done` pulse in the next cycle. The three pointer modes read a 16-bit pointer over a byte-wide read port. The port has one cycle of read latency, and the unit reads the low byte first. While a resolution is in progress, `start` has no effect. `kind` and `value` are valid in the `done` cycle and keep their values until the next `done`.

Top module: `ea_unit`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, `done` and `rd_en` are low and the unit is idle.
- R2: Mode codes 0 (implied), 1 (accumulator) and 13 to 15 (unassigned) give `kind` = 0 (none) with `value` = 0.
- R3: Mode code 2 (immediate) gives `kind` = 1 with `value` = {8'h00, `op_lo`}.
- R4: Mode codes 3, 4 and 5 (page-zero, page-zero plus X, page-zero plus Y) give `kind` = 3. `value[7:0]` is `op_lo`, `op_lo`+X or `op_lo`+Y, each taken modulo 256, and `value[15:8]` is 0. For example, 250 plus X=9 gives 3.
- R5: Mode code 6 (relative) gives `kind` = 2 with `value` = `op_lo` sign-extended, so the high byte is 8'hFF when `op_lo[7]` is 1 and 8'h00 otherwise.
- R6: Mode codes 7, 8 and 9 (absolute, absolute plus X, absolute plus Y) give `kind` = 3. The base address is {`op_hi`, `op_lo`}, with `op_lo` as the low byte. Codes 8 and 9 add the zero-extended X or Y modulo 65536.
- R7: Mode code 10 (pointer) reads the low byte at {`op_hi`,`op_lo`} and then the high byte at that pointer plus 1 modulo 65536. It gives `kind` = 3 with the assembled word.
- R8: Mode code 11 (pre-indexed pointer) uses the pointer (`op_lo`+X) mod 256 and fetches the high byte at that pointer plus 1 with a 16-bit increment, so pointer 8'hFF reads its high byte at 16'h0100. The fetched word is the result, with `kind` = 3.
- R9: Mode code 12 (post-indexed pointer) fetches a word at the page-zero pointer `op_lo`, again with a 16-bit increment for the high byte. It then adds the X-independent zero-extended Y, modulo 65536, and gives `kind` = 3.
- R10: Suppose `start` is sampled at edge k. Direct modes raise `done` after edge k+1 only... more precisely, `done` is high in the cycle after edge k. Pointer modes drive `rd_en` in the two cycles after edges k and k+1, low address first. Read data is taken one cycle after each strobe, and `done` is high in the cycle after edge k+3. `done` lasts one cycle for each accepted start.
- R11: A `start` that arrives while a pointer fetch is in progress is ignored. It causes no `done`, no read, and no change to the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a resolution |
| mode | input | 4 | Addressing mode code (see requirements) |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after the strobe |
| done | output | 1 | Result valid pulse |
| kind | output | 2 | 0 none, 1 immediate, 2 relative, 3 address |
| value | output | 16 | Resolved operand |

## Verification
Some properties are checked by assertions on every cycle:
- pointer reads come in exactly two adjacent strobes, with the second address one above the first;
- a read pair begins only right after an accepted start;
- `done` follows the end of a read pair;
- page-zero results keep a zero high byte, relative results are properly sign-extended, and empty results are zero.

Other properties need the bench's scenarios, which check values against a cycle-level reference model:
- the arithmetic values for each mode;
- wraparound at 8 and 16 bits;
- the 16-bit high-byte fetch increment at 8'hFF and 16'hFFFF;
- the X-then-fetch versus fetch-then-Y ordering;
- a start that arrives while the unit is busy having no effect.

// File: rtl/eagu_pkg.sv
package eagu_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  localparam logic [3:0] AM_IMPL = 4'd0;
  localparam logic [3:0] AM_ACC  = 4'd1;
  localparam logic [3:0] AM_IMM  = 4'd2;
  localparam logic [3:0] AM_ZP   = 4'd3;
  localparam logic [3:0] AM_ZPX  = 4'd4;
  localparam logic [3:0] AM_ZPY  = 4'd5;
  localparam logic [3:0] AM_REL  = 4'd6;
  localparam logic [3:0] AM_ABS  = 4'd7;
  localparam logic [3:0] AM_ABSX = 4'd8;
  localparam logic [3:0] AM_ABSY = 4'd9;
  localparam logic [3:0] AM_IND  = 4'd10;
  localparam logic [3:0] AM_INDX = 4'd11;
  localparam logic [3:0] AM_INDY = 4'd12;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_IMM  = 2'd1,
    RK_REL  = 2'd2,
    RK_ADDR = 2'd3
  } rkind_e;

  // page-zero sum: the carry out of the low byte is dropped
  function automatic logic [ADDR_W-1:0] zp_sum(input logic [BYTE_W-1:0] b,
                                               input logic [BYTE_W-1:0] i);
    logic [BYTE_W-1:0] s;
    s = b + i;
    return {{BYTE_W{1'b0}}, s};
  endfunction

  function automatic logic [ADDR_W-1:0] sext_byte(input logic [BYTE_W-1:0] b);
    return {{BYTE_W{b[BYTE_W-1]}}, b};
  endfunction

  function automatic logic [ADDR_W-1:0] join_le(input logic [BYTE_W-1:0] lo,
                                                input logic [BYTE_W-1:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic [ADDR_W-1:0] add_index(input logic [ADDR_W-1:0] w,
                                                  input logic [BYTE_W-1:0] i);
    return w + {{BYTE_W{1'b0}}, i};
  endfunction

  function automatic logic needs_fetch(input logic [3:0] m);
    return (m == AM_IND) || (m == AM_INDX) || (m == AM_INDY);
  endfunction

  function automatic logic is_page_zero(input logic [3:0] m);
    return (m == AM_ZP) || (m == AM_ZPX) || (m == AM_ZPY);
  endfunction
endpackage

// File: rtl/ea_direct.sv
module ea_direct
  import eagu_pkg::*;
(
  input  logic [3:0]        mode,
  input  logic [BYTE_W-1:0] op_lo,
  input  logic [BYTE_W-1:0] op_hi,
  input  logic [BYTE_W-1:0] idx_x,
  input  logic [BYTE_W-1:0] idx_y,
  output rkind_e            kind,
  output logic [ADDR_W-1:0] value,
  output logic              fetch,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] base_abs;

  assign base_abs = join_le(op_lo, op_hi);
  assign fetch    = needs_fetch(mode);

  always_comb begin
    kind  = RK_ADDR;
    value = '0;
    unique case (mode)
      AM_IMM:  begin kind = RK_IMM; value = {{BYTE_W{1'b0}}, op_lo}; end
      AM_REL:  begin kind = RK_REL; value = sext_byte(op_lo); end
      AM_ZP:   value = zp_sum(op_lo, '0);
      AM_ZPX:  value = zp_sum(op_lo, idx_x);
      AM_ZPY:  value = zp_sum(op_lo, idx_y);
      AM_ABS:  value = base_abs;
      AM_ABSX: value = add_index(base_abs, idx_x);
      AM_ABSY: value = add_index(base_abs, idx_y);
      AM_IND, AM_INDX, AM_INDY: value = '0;
      default: begin kind = RK_NONE; value = '0; end
    endcase
  end

  // pointer for the fetch modes; X is applied before the fetch
  always_comb begin
    unique case (mode)
      AM_INDX: ptr = zp_sum(op_lo, idx_x);
      AM_INDY: ptr = zp_sum(op_lo, '0);
      default: ptr = base_abs;
    endcase
  end
endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch
  import eagu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] ptr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              idle,
  output logic              word_vld,
  output logic [ADDR_W-1:0] word
);
  typedef enum logic [1:0] {FS_IDLE, FS_LO, FS_HI, FS_TAIL} fstate_e;

  fstate_e           st_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= FS_IDLE;
      ptr_q <= '0;
      lo_q  <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (go) begin st_q <= FS_LO; ptr_q <= ptr; end
        FS_LO:   st_q <= FS_HI;
        FS_HI:   begin st_q <= FS_TAIL; lo_q <= rd_data; end
        FS_TAIL: st_q <= FS_IDLE;
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  // the high byte sits at pointer+1 with a full 16-bit carry
  assign rd_en    = (st_q == FS_LO) || (st_q == FS_HI);
  assign rd_addr  = (st_q == FS_HI) ? ptr_q + 1'b1 : ptr_q;
  assign idle     = (st_q == FS_IDLE);
  assign word_vld = (st_q == FS_TAIL);
  assign word     = join_le(lo_q, rd_data);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import eagu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [BYTE_W-1:0] op_lo,
  input  logic [BYTE_W-1:0] op_hi,
  input  logic [BYTE_W-1:0] idx_x,
  input  logic [BYTE_W-1:0] idx_y,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              done,
  output logic [1:0]        kind,
  output logic [ADDR_W-1:0] value
);
  rkind_e            dir_kind;
  logic [ADDR_W-1:0] dir_value;
  logic              dir_fetch;
  logic [ADDR_W-1:0] dir_ptr;

  logic              fetch_idle;
  logic              word_vld;
  logic [ADDR_W-1:0] word;

  // named internal events, used by the bound checker
  logic              accept;
  logic              accept_fetch;
  logic [3:0]        res_mode_q;

  logic [BYTE_W-1:0] post_idx_q;
  logic              done_q;
  rkind_e            kind_q;
  logic [ADDR_W-1:0] value_q;

  assign accept       = start && fetch_idle;
  assign accept_fetch = accept && dir_fetch;

  ea_direct u_direct (
    .mode  (mode),
    .op_lo (op_lo),
    .op_hi (op_hi),
    .idx_x (idx_x),
    .idx_y (idx_y),
    .kind  (dir_kind),
    .value (dir_value),
    .fetch (dir_fetch),
    .ptr   (dir_ptr)
  );

  ea_ptr_fetch u_fetch (
    .clk      (clk),
    .rst      (rst),
    .go       (accept_fetch),
    .ptr      (dir_ptr),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .idle     (fetch_idle),
    .word_vld (word_vld),
    .word     (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q     <= 1'b0;
      kind_q     <= RK_NONE;
      value_q    <= '0;
      post_idx_q <= '0;
      res_mode_q <= AM_IMPL;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        res_mode_q <= mode;
        post_idx_q <= (mode == AM_INDY) ? idx_y : '0;
        if (!dir_fetch) begin
          done_q  <= 1'b1;
          kind_q  <= dir_kind;
          value_q <= dir_value;
        end
      end else if (word_vld) begin
        // Y is applied after the fetch
        done_q  <= 1'b1;
        kind_q  <= RK_ADDR;
        value_q <= add_index(word, post_idx_q);
      end
    end
  end

  assign done  = done_q;
  assign kind  = kind_q;
  assign value = value_q;
endmodule

// File: rtl/ea_unit_checker.sv
module ea_unit_checker
  import eagu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              done,
  input logic [1:0]        kind,
  input logic [ADDR_W-1:0] value,
  input logic              accept,
  input logic [3:0]        res_mode_q
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !rd_en));

  a_r10_read_pair_second: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |=> rd_en);

  a_r10_read_pair_ends: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |=> !rd_en);

  a_r7_high_addr_next: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 16'd1));

  a_r11_reads_follow_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> $past(accept));

  a_r10_done_after_reads: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_en) |=> done);

  a_r4_page_zero_high: assert property (@(posedge clk) disable iff (rst)
    (done && is_page_zero(res_mode_q)) |-> (value[15:8] == 8'h00 && kind == 2'd3));

  a_r5_rel_sign: assert property (@(posedge clk) disable iff (rst)
    (done && kind == 2'd2) |-> (value[15:8] == {8{value[7]}}));

  a_r2_none_zero: assert property (@(posedge clk) disable iff (rst)
    (done && kind == 2'd0) |-> (value == 16'h0000));

  a_r3_imm_high_zero: assert property (@(posedge clk) disable iff (rst)
    (done && kind == 2'd1) |-> (value[15:8] == 8'h00));
endmodule

bind ea_unit ea_unit_checker u_checker (
  .clk        (clk),
  .rst        (rst),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .done       (done),
  .kind       (kind),
  .value      (value),
  .accept     (accept),
  .res_mode_q (res_mode_q)
);

// File: tb/ea_unit_tb.sv
module ea_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        done;
  logic [1:0]  kind;
  logic [15:0] value;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  ea_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .op_lo(op_lo),
    .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .kind(kind),
    .value(value)
  );

  function automatic int mem_byte(int a);
    return ((a % 256) * 7 + (a / 256) * 3 + 90) % 256;
  endfunction

  // behavioural memory with one cycle of read latency
  always @(posedge clk) if (rd_en) rd_data <= 8'(mem_byte(int'(rd_addr)));

  task automatic chk(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference model state
  int    m_cnt = 0;
  bit    e_done = 0, e_rd = 0;
  int    e_kind = 0, e_val = 0, e_ptr = 0, e_rda = 0;
  string e_tag = "R2";

  task automatic expect_of(int md, int lo, int hi, int x, int y,
                           output int k, output int v, output bit ind,
                           output int p, output string tag);
    int w;
    ind = 0; p = 0; k = 3; v = 0;
    case (md)
      2:  begin k = 1; v = lo; tag = "R3"; end
      3:  begin v = lo; tag = "R4"; end
      4:  begin v = (lo + x) % 256; tag = "R4"; end
      5:  begin v = (lo + y) % 256; tag = "R4"; end
      6:  begin k = 2; v = (lo >= 128) ? 65280 + lo : lo; tag = "R5"; end
      7:  begin v = hi * 256 + lo; tag = "R6"; end
      8:  begin v = (hi * 256 + lo + x) % 65536; tag = "R6"; end
      9:  begin v = (hi * 256 + lo + y) % 65536; tag = "R6"; end
      10: begin ind = 1; p = hi * 256 + lo; tag = "R7"; end
      11: begin ind = 1; p = (lo + x) % 256; tag = "R8"; end
      12: begin ind = 1; p = lo; tag = "R9"; end
      default: begin k = 0; v = 0; tag = "R2"; end
    endcase
    if (ind) begin
      w = mem_byte(p) + 256 * mem_byte((p + 1) % 65536);
      v = (md == 12) ? (w + y) % 65536 : w;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; e_done = 0; e_rd = 0;
    end else begin
      e_done = 0; e_rd = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) e_done = 1;
      end else if (start) begin
        bit ind;
        expect_of(int'(mode), int'(op_lo), int'(op_hi), int'(idx_x), int'(idx_y),
                  e_kind, e_val, ind, e_ptr, e_tag);
        if (ind) m_cnt = 3; else e_done = 1;
      end
      if (m_cnt == 3) begin e_rd = 1; e_rda = e_ptr; end
      else if (m_cnt == 2) begin e_rd = 1; e_rda = (e_ptr + 1) % 65536; end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R10", int'(done), int'(e_done), "done");
      chk("R10", int'(rd_en), int'(e_rd), "rd_en");
      if (e_rd) chk(e_tag, int'(rd_addr), e_rda, "rd_addr");
      if (e_done) begin
        chk(e_tag, int'(kind), e_kind, "kind");
        chk(e_tag, int'(value), e_val, "value");
      end
    end
  end

  task automatic run(int md, int lo, int hi, int x, int y);
    @(negedge clk);
    mode = 4'(md); op_lo = 8'(lo); op_hi = 8'(hi); idx_x = 8'(x); idx_y = 8'(y);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    chk("R1", int'(done), 0, "done in reset");
    chk("R1", int'(rd_en), 0, "rd_en in reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", int'(done), 0, "done after reset");

    run(0, 8'h12, 8'h34, 1, 2);          // R2 implied
    run(1, 8'hAB, 8'hCD, 1, 2);          // R2 accumulator
    run(14, 8'h55, 8'h66, 1, 2);         // R2 unassigned code
    run(2, 8'hC3, 8'h99, 0, 0);          // R3
    run(3, 8'h80, 8'h77, 5, 6);          // R4
    run(4, 10, 0, 9, 0);                 // R4: 19
    run(4, 250, 0, 9, 0);                // R4: wraps to 3
    run(5, 8'hF0, 8'h11, 0, 8'h20);      // R4: wraps to 0x10
    run(6, 8'h80, 0, 0, 0);              // R5
    run(6, 8'h7F, 0, 0, 0);              // R5
    run(6, 8'hFE, 0, 0, 0);              // R5
    run(7, 8'h34, 8'h12, 0, 0);          // R6 little-endian
    run(8, 8'hFF, 8'hFF, 1, 0);          // R6 wraps to 0
    run(9, 8'hF0, 8'h12, 0, 8'h20);      // R6 carry into high byte
    run(10, 8'hFF, 8'h12, 0, 0);         // R7 high byte at 0x1300
    run(10, 8'hFF, 8'hFF, 0, 0);         // R7 high byte at 0x0000
    run(11, 8'hFF, 8'h00, 0, 0);         // R8 high byte at 0x0100
    run(11, 8'hF0, 8'h00, 8'h20, 0);     // R8 pointer wraps to 0x10
    run(12, 8'h40, 8'h00, 8'h33, 8'hFF); // R9
    run(12, 8'hFF, 8'h00, 0, 8'h80);     // R9 16-bit fetch increment

    // R10: back-to-back direct starts each give their own done
    @(negedge clk);
    mode = 4'd2; op_lo = 8'h11; start = 1'b1;
    @(negedge clk);
    op_lo = 8'h22;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);

    // R11: a start during a pointer fetch is ignored
    @(negedge clk);
    mode = 4'd10; op_lo = 8'h00; op_hi = 8'h20; start = 1'b1;
    @(negedge clk);
    mode = 4'd2; op_lo = 8'h99;
    @(negedge clk);
    mode = 4'd12;
    @(negedge clk);
    start = 1'b0;
    chk("R11", int'(done), 0, "no done from busy start");
    repeat (5) @(negedge clk);

    seed = 12345;
    for (int i = 0; i < 300; i++) begin
      int r;
      seed = (seed * 1103515 + 12345) % 2147483;
      if (seed < 0) seed = -seed;
      r = seed;
      run(r % 16, (r / 16) % 256, (r / 4096) % 256, (r / 7) % 256, (r / 13) % 256);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule